// File: doc/BRIEF.md
# I2C Bus Fault Detector

This block sits beside the byte engine of an I2C controller and watches the bus for three kinds of fault. The first is a bus error: a start or stop condition appears in the middle of a byte while the controller is a slave. The second is an acknowledge failure: the acknowledge bit sampled by the controller reads as a NACK. The third is an arbitration loss: while the controller is master during a byte, the line reads low at an SCL rising edge although the local driver has released SDA high. An SDA edge during SCL high inside a master byte also counts as arbitration loss, and is not reported as a start or stop.

The raw SCL and SDA pins pass through a synchronizer of SYNC_STAGES flops, which defaults to two. Edges are found by comparing each synchronized value with its value one cycle earlier. Each fault sets a sticky flag that the status logic reads. The flags also drive a general event flag and an interrupt request. The interrupt request is gated by an enable input, but the flags are set whatever the enable is.

A fault that occurs while the controller is master produces a one-cycle request to drop to slave mode. Any fault makes the block tell the clock logic to release SCL. SDA is left alone, so that later software action can release it. A single clear input removes all flags and the SCL release.

The controller follows one of three states:
- ST_SLAVE is entered at reset and after a clear.
- ST_SLAVE goes to ST_MASTER when master_mode is high and no fault is present.
- ST_MASTER goes back to ST_SLAVE when master_mode falls.
- ST_SLAVE or ST_MASTER goes to ST_FAULT on any new fault.
- ST_FAULT goes to ST_SLAVE on err_clear.
- From every state, err_clear leads to ST_SLAVE. It has priority over a fault detected in the same cycle.

Top module: `i2c_fault_watch`

## Requirements
- R1: After reset all outputs are low. The synchronized lines start at the idle-high level.
- R2: When byte_busy is high and master_mode is low, a start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) sets bus_err and event_flag.
- R3: A start or stop seen while byte_busy is low sets no flag.
- R4: A cycle with ack_strobe high and ack_bit high (1 means NACK) sets ack_fail. A cycle with ack_strobe high and ack_bit low sets no flag.
- R5: arb_lost is set when all of these hold at an SCL rising edge: master_mode and byte_busy are high, sda_drive is 1 (released), and SDA reads 0. If the block is in ST_MASTER, drop_master is high for exactly one cycle.
- R6: At an SCL rising edge with SDA reading 0, no arbitration loss is flagged if sda_drive is 0. No arbitration loss is flagged either if master_mode is low.
- R7: An SDA edge while SCL is high, with master_mode and byte_busy both high, sets arb_lost and leaves bus_err clear.
- R8: Any fault sets scl_release. scl_release stays high until err_clear.
- R9: irq equals event_flag ANDed with int_enable. The flags are set even when int_enable is low.
- R10: Flags are sticky. A one-cycle err_clear drops all flags, event_flag, irq and scl_release on the next cycle.
- R11: drop_master never pulses for a fault that occurs in ST_SLAVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| sda_drive | input | 1 | Value the local master drives on SDA (1 = released) |
| master_mode | input | 1 | Controller is bus master |
| byte_busy | input | 1 | A byte transfer is in progress |
| ack_strobe | input | 1 | One-cycle strobe marking the sampled acknowledge bit |
| ack_bit | input | 1 | Sampled acknowledge bit, 1 = NACK |
| int_enable | input | 1 | Interrupt enable |
| err_clear | input | 1 | Clears all flags and the SCL release |
| bus_err | output | 1 | Sticky bus error flag |
| ack_fail | output | 1 | Sticky acknowledge failure flag |
| arb_lost | output | 1 | Sticky arbitration loss flag |
| event_flag | output | 1 | Any flag set |
| irq | output | 1 | Interrupt request |
| drop_master | output | 1 | One-cycle request to leave master mode |
| scl_release | output | 1 | Release SCL after a fault |

## Verification
The assertions take for granted that master_mode, byte_busy, sda_drive, ack_strobe and err_clear are synchronous to clk and stable between controller decisions. They also assume that err_clear is a single-cycle pulse. The stimulus changes the controller inputs only at falling clock edges and moves only one bus line at a time. Between line moves it waits several cycles, so the synchronizer and edge detector see each change on its own. Data-bit moves of SDA happen only while SCL is low, except where a test deliberately creates a start or stop condition.

// File: rtl/i2c_fault_pkg.sv
package i2c_fault_pkg;

    typedef enum logic [1:0] {
        ST_SLAVE  = 2'd0,
        ST_MASTER = 2'd1,
        ST_FAULT  = 2'd2
    } fsm_state_t;

    typedef struct packed {
        logic arb;
        logic ack;
        logic bus;
    } err_vec_t;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced,
    output logic [LINES-1:0] prior
);

    localparam int TOP = STAGES - 1;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              last;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                    last  <= 1'b1;
                end else begin
                    chain <= {chain[TOP-1:0], raw[g]};
                    last  <= chain[TOP];
                end
            end

            assign synced[g] = chain[TOP];
            assign prior[g]  = last;
        end
    endgenerate

    initial begin
        assert_stage_count_R1: assert (STAGES >= 2)
            else $error("synchronizer needs at least two stages");
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_fault_pkg::*;
(
    input  logic     scl_s,
    input  logic     scl_p,
    input  logic     sda_s,
    input  logic     sda_p,
    input  logic     sda_drive,
    input  logic     master_mode,
    input  logic     byte_busy,
    input  logic     ack_strobe,
    input  logic     ack_bit,
    output err_vec_t new_err
);

    logic scl_high;
    logic scl_rise;
    logic start_seen;
    logic stop_seen;
    logic master_byte;
    logic slave_byte;
    logic line_mismatch;

    always_comb begin
        scl_high      = scl_s & scl_p;
        scl_rise      = scl_s & ~scl_p;
        start_seen    = scl_high & sda_p & ~sda_s;
        stop_seen     = scl_high & ~sda_p & sda_s;
        master_byte   = master_mode & byte_busy;
        slave_byte    = ~master_mode & byte_busy;
        line_mismatch = scl_rise & sda_drive & ~sda_s;

        new_err.bus = slave_byte & (start_seen | stop_seen);
        new_err.arb = master_byte & (line_mismatch | start_seen | stop_seen);
        new_err.ack = ack_strobe & ack_bit;
    end

endmodule

// File: rtl/i2c_fault_fsm.sv
module i2c_fault_fsm
    import i2c_fault_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  err_vec_t new_err,
    input  logic     master_mode,
    input  logic     int_enable,
    input  logic     err_clear,
    output err_vec_t flags,
    output logic     event_flag,
    output logic     irq,
    output logic     drop_master,
    output logic     scl_release
);

    fsm_state_t state_q;
    fsm_state_t state_d;
    err_vec_t   flags_q;
    logic       any_new;

    assign any_new = |new_err;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLAVE: begin
                if (any_new)          state_d = ST_FAULT;
                else if (master_mode) state_d = ST_MASTER;
            end
            ST_MASTER: begin
                if (any_new)           state_d = ST_FAULT;
                else if (!master_mode) state_d = ST_SLAVE;
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: state_d = ST_SLAVE;
        endcase
        if (err_clear) state_d = ST_SLAVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLAVE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flags_q <= '0;
        else if (err_clear) flags_q <= '0;
        else                flags_q <= flags_q | new_err;
    end

    always_comb begin
        flags       = flags_q;
        event_flag  = |flags_q;
        irq         = event_flag & int_enable;
        drop_master = (state_q == ST_MASTER) & any_new & ~err_clear;
        scl_release = (state_q == ST_FAULT);
    end

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear |=> (flags_q == '0 && !scl_release));

    assert_drop_then_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_master |=> scl_release);

    assert_release_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_release) |-> $past(any_new));

    assert_arb_in_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.arb) |-> $past(master_mode));

endmodule

// File: rtl/i2c_fault_watch.sv
module i2c_fault_watch
    import i2c_fault_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_drive,
    input  logic master_mode,
    input  logic byte_busy,
    input  logic ack_strobe,
    input  logic ack_bit,
    input  logic int_enable,
    input  logic err_clear,
    output logic bus_err,
    output logic ack_fail,
    output logic arb_lost,
    output logic event_flag,
    output logic irq,
    output logic drop_master,
    output logic scl_release
);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] prior_lines;
    err_vec_t             new_err;
    err_vec_t             flags;

    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_SCL] = scl_in;
        raw_lines[LINE_SDA] = sda_in;
    end

    i2c_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (NUM_LINES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_lines),
        .synced (sync_lines),
        .prior  (prior_lines)
    );

    i2c_cond_detect u_detect (
        .scl_s       (sync_lines[LINE_SCL]),
        .scl_p       (prior_lines[LINE_SCL]),
        .sda_s       (sync_lines[LINE_SDA]),
        .sda_p       (prior_lines[LINE_SDA]),
        .sda_drive   (sda_drive),
        .master_mode (master_mode),
        .byte_busy   (byte_busy),
        .ack_strobe  (ack_strobe),
        .ack_bit     (ack_bit),
        .new_err     (new_err)
    );

    i2c_fault_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .new_err     (new_err),
        .master_mode (master_mode),
        .int_enable  (int_enable),
        .err_clear   (err_clear),
        .flags       (flags),
        .event_flag  (event_flag),
        .irq         (irq),
        .drop_master (drop_master),
        .scl_release (scl_release)
    );

    assign bus_err  = flags.bus;
    assign ack_fail = flags.ack;
    assign arb_lost = flags.arb;

    assert_bus_err_slave_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(byte_busy && !master_mode));

    assert_no_drop_slave_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drop_master |-> master_mode);

endmodule

// File: tb/tb_i2c_fault_watch.sv
`timescale 1ns/1ps
module tb_i2c_fault_watch;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, sda_drive = 1'b1;
    logic master_mode = 1'b0, byte_busy = 1'b0, ack_strobe = 1'b0, ack_bit = 1'b0;
    logic int_enable = 1'b0, err_clear = 1'b0;
    logic bus_err, ack_fail, arb_lost, event_flag, irq, drop_master, scl_release;

    int checks = 0;
    int errors = 0;
    int drop_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_fault_watch dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_drive(sda_drive), .master_mode(master_mode), .byte_busy(byte_busy),
        .ack_strobe(ack_strobe), .ack_bit(ack_bit), .int_enable(int_enable),
        .err_clear(err_clear), .bus_err(bus_err), .ack_fail(ack_fail),
        .arb_lost(arb_lost), .event_flag(event_flag), .irq(irq),
        .drop_master(drop_master), .scl_release(scl_release)
    );

    always @(negedge clk) if (rst_n && drop_master) drop_cnt++;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_scl(input logic v);
        scl_in = v; step(5);
    endtask

    task automatic set_sda(input logic v);
        sda_in = v; step(5);
    endtask

    task automatic clear_all;
        err_clear = 1'b1; step(1);
        err_clear = 1'b0; step(1);
    endtask

    task automatic idle_bus;
        byte_busy = 1'b0; master_mode = 1'b0; sda_drive = 1'b1;
        set_scl(1'b1); set_sda(1'b1);
        clear_all();
    endtask

    task automatic t_reset;
        chk("R1 bus_err", bus_err, 1'b0);
        chk("R1 ack_fail", ack_fail, 1'b0);
        chk("R1 arb_lost", arb_lost, 1'b0);
        chk("R1 event_flag", event_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 drop_master", drop_master, 1'b0);
        chk("R1 scl_release", scl_release, 1'b0);
    endtask

    task automatic t_start_in_byte;
        int d0 = drop_cnt;
        byte_busy = 1'b1; step(2);
        set_sda(1'b0);
        chk("R2 start bus_err", bus_err, 1'b1);
        chk("R2 start event_flag", event_flag, 1'b1);
        chk("R8 release after bus error", scl_release, 1'b1);
        chk("R11 no drop in slave", (drop_cnt == d0), 1'b1);
        chk("R9 irq gated off", irq, 1'b0);
        int_enable = 1'b1; step(1);
        chk("R9 irq enabled", irq, 1'b1);
        int_enable = 1'b0;
        idle_bus();
        chk("R10 cleared bus_err", bus_err, 1'b0);
        chk("R10 cleared release", scl_release, 1'b0);
    endtask

    task automatic t_stop_in_byte;
        byte_busy = 1'b0;
        set_scl(1'b0); set_sda(1'b0); set_scl(1'b1);
        byte_busy = 1'b1; step(2);
        set_sda(1'b1);
        chk("R2 stop bus_err", bus_err, 1'b1);
        idle_bus();
    endtask

    task automatic t_legal_conditions;
        byte_busy = 1'b0;
        set_sda(1'b0);
        set_sda(1'b1);
        chk("R3 start/stop outside byte", event_flag, 1'b0);
        chk("R3 no release", scl_release, 1'b0);
    endtask

    task automatic t_ack;
        ack_bit = 1'b0; ack_strobe = 1'b1; step(1);
        ack_strobe = 1'b0; step(2);
        chk("R4 ack ok no flag", event_flag, 1'b0);
        ack_bit = 1'b1; ack_strobe = 1'b1; step(1);
        ack_strobe = 1'b0; ack_bit = 1'b0; step(2);
        chk("R4 nack ack_fail", ack_fail, 1'b1);
        chk("R4 nack event_flag", event_flag, 1'b1);
        step(10);
        chk("R10 ack_fail sticky", ack_fail, 1'b1);
        int_enable = 1'b1; step(1);
        chk("R9 irq from ack_fail", irq, 1'b1);
        clear_all();
        chk("R10 irq cleared", irq, 1'b0);
        chk("R10 ack_fail cleared", ack_fail, 1'b0);
        int_enable = 1'b0;
    endtask

    task automatic t_arb_mismatch;
        int d0;
        master_mode = 1'b1; sda_drive = 1'b1; step(3);
        d0 = drop_cnt;
        set_scl(1'b0);
        byte_busy = 1'b1;
        set_sda(1'b0);
        set_scl(1'b1);
        chk("R5 arb_lost", arb_lost, 1'b1);
        chk("R5 drop one pulse", (drop_cnt == d0 + 1), 1'b1);
        chk("R5 bus_err clear", bus_err, 1'b0);
        chk("R8 release after arb", scl_release, 1'b1);
        step(6);
        chk("R8 release held", scl_release, 1'b1);
        idle_bus();
    endtask

    task automatic t_arb_no_error;
        master_mode = 1'b1; sda_drive = 1'b0; step(3);
        set_scl(1'b0);
        byte_busy = 1'b1;
        set_sda(1'b0);
        set_scl(1'b1);
        chk("R6 driven low no arb", arb_lost, 1'b0);
        set_scl(1'b0);
        master_mode = 1'b0; sda_drive = 1'b1; step(2);
        set_scl(1'b1);
        chk("R6 slave no arb", event_flag, 1'b0);
        idle_bus();
    endtask

    task automatic t_misplaced;
        int d0;
        master_mode = 1'b1; sda_drive = 1'b1; step(3);
        byte_busy = 1'b1; step(2);
        d0 = drop_cnt;
        set_sda(1'b0);
        chk("R7 misplaced arb_lost", arb_lost, 1'b1);
        chk("R7 misplaced not bus_err", bus_err, 1'b0);
        chk("R5 drop on misplaced", (drop_cnt == d0 + 1), 1'b1);
        idle_bus();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(3);
        t_reset();
        t_start_in_byte();
        t_stop_in_byte();
        t_legal_conditions();
        t_ack();
        t_arb_mismatch();
        t_arb_no_error();
        t_misplaced();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule